// File: doc/BRIEF.md
# Audio Link Transmit Slot FIFO

This block holds outgoing 16-bit audio samples written by a processor and hands them out, one per request, to the frame builder of an AC'97-style serial link. A frame builder asks for each slot of a frame in turn by raising a request strobe with the slot number. When the number matches the slot this FIFO is tied to, the block answers on the following clock with a 20-bit slot value. This value holds the sample left-aligned, or zeros if no sample was waiting.

A 16-bit control and status word sets the block up. It holds a connection-enable code, a mono or stereo choice, a slot code and an interrupt threshold, and it carries a DMA-enable bit that is passed out to the surrounding logic. In stereo mode the FIFO answers for its slot and for the slot after it, so left and right samples written in turn go out in the right places. A level interrupt tells software that enough space has opened up to write more samples. A sticky flag records that a slot was served with no data behind it.

Top module: `aud_tx_slot_fifo`

## Requirements
- R1: After reset the control word reads 16'h4000: all control fields zero, the empty flag (bit 14) set, the full flag (bit 13) and the underflow flag (bit 15) clear. Also after reset `irq` and `slot_valid` are low.
- R2: The FIFO stores eight 16-bit samples and sends them out in the order they were written. A sample written while eight are held is dropped. Bit 13 reads 1 while eight samples are held, and bit 14 reads 1 while none are held.
- R3: Slots are served only while control bits 1:0 equal 2'b10. With 2'b00, 2'b01 or 2'b11, a request produces no `slot_valid`, removes no sample and does not set the underflow flag.
- R4: In mono mode (bit 3 = 0), slot codes 3 to 12 in bits 7:4 serve only the slot whose number equals the code. Codes 0 to 2 and 13 to 15 serve no slot.
- R5: In stereo mode (bit 3 = 1), slot codes 3 to 11 serve the coded slot and the next one. Code 12 serves no slot in stereo mode.
- R6: In stereo mode, a request for the lower slot followed by a request for the upper slot takes two samples in write order. The first (left) sample goes to the lower slot and the second (right) sample goes to the upper slot.
- R7: A served request raises `slot_valid` for exactly one cycle, on the clock after the request. During that cycle `slot_data` equals the sample in bits 19:4, with bits 3:0 zero.
- R8: A served request that finds the FIFO empty returns `slot_data` = 0 and sets bit 15. Bit 15 stays set until a control write with bit 15 = 1. A write with bit 15 = 0 leaves it unchanged.
- R9: `irq` is high exactly while the link is enabled (bits 1:0 = 2'b10) and the number of free entries is at least bits 10:8 plus one.
- R10: Write data in bits 2, 12, 13 and 14 is ignored. Bits 2 and 12 always read 0, and bits 13 and 14 read back the FIFO status.
- R11: Bit 11 is stored as written, reads back, and drives the `dma_en` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control and status readback |
| smp_wr | input | 1 | Sample write strobe |
| smp_wdata | input | 16 | Sample to queue |
| slot_req | input | 1 | Frame builder asks for a slot value |
| slot_num | input | 4 | Number of the slot being asked for |
| slot_valid | output | 1 | This FIFO answered the previous request |
| slot_data | output | 20 | Slot value, sample in bits 19:4 |
| irq | output | 1 | Level interrupt: enough free entries |
| dma_en | output | 1 | DMA enable bit from the control word |

## Verification
A wrong read or write pointer shows up on the first served slot after it goes wrong, as a sample out of order. A wrong entry count shows up at once in the full and empty readback bits and in `irq`, and on the next request as a false underflow or a missing one. A bad stereo or slot decode shows up as a `slot_valid` pulse on a slot that should be silent, or as a missing pulse one clock after a slot that should be served. The scoreboard catches this because every pulse it does not expect is counted.

// File: rtl/aud_tx_pkg.sv
// Package: shared types and constants for the transmit slot FIFO.
// Assumes a fixed 16-bit control word; field positions are part of the
// software-visible layout and must not move.
package aud_tx_pkg;

    localparam logic [1:0] LINK_ON   = 2'b10;
    localparam logic [3:0] SLOT_LOW  = 4'd3;
    localparam logic [3:0] SLOT_HIGH = 4'd12;

    localparam int UF_BIT    = 15;
    localparam int EMPTY_BIT = 14;
    localparam int FULL_BIT  = 13;
    localparam int DMA_BIT   = 11;

    // Stored configuration fields of the control word
    typedef struct packed {
        logic       dma;
        logic [2:0] thresh;
        logic [3:0] slot;
        logic       stereo;
        logic [1:0] link;
    } tx_cfg_t;

endpackage

// File: rtl/aud_tx_fifo_mem.sv
// Module: circular sample store with write and read pointers and an entry
// count. Assumes DEPTH >= 2. A push while full is dropped, and a pop while
// empty is ignored. The head sample is presented combinationally.
module aud_tx_fifo_mem #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    level
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store an accepted sample at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and track the number of held entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R2: a write into a full store without a read leaves it full
    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R2: full and empty are never reported together
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

endmodule

// File: rtl/aud_tx_ctrl_reg.sv
// Module: control and status word. Holds the configuration fields and the
// sticky underflow flag, and assembles the readback value. Assumes uf_set
// comes from the slot server; a set in the same cycle as a clear wins.
module aud_tx_ctrl_reg
    import aud_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wdata,
    input  logic        uf_set,
    input  logic        full,
    input  logic        empty,
    output tx_cfg_t     cfg,
    output logic        uf_flag,
    output logic [15:0] rdata
);

    // Capture the writable configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.link   <= wdata[1:0];
            cfg.stereo <= wdata[3];
            cfg.slot   <= wdata[7:4];
            cfg.thresh <= wdata[10:8];
            cfg.dma    <= wdata[DMA_BIT];
        end
    end

    // Sticky underflow: set by the slot server, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_flag <= 1'b0;
        end else if (uf_set) begin
            uf_flag <= 1'b1;
        end else if (wr_en && wdata[UF_BIT]) begin
            uf_flag <= 1'b0;
        end
    end

    // Assemble the readback word; reserved positions read zero
    always_comb begin
        rdata            = '0;
        rdata[1:0]       = cfg.link;
        rdata[3]         = cfg.stereo;
        rdata[7:4]       = cfg.slot;
        rdata[10:8]      = cfg.thresh;
        rdata[DMA_BIT]   = cfg.dma;
        rdata[FULL_BIT]  = full;
        rdata[EMPTY_BIT] = empty;
        rdata[UF_BIT]    = uf_flag;
    end

    // R8: an underflow event is always recorded
    p_uf_recorded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uf_set |=> uf_flag);

    // R8: the flag only drops through a write-one clear
    p_uf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_flag && !(wr_en && wdata[UF_BIT])) |=> uf_flag);

endmodule

// File: rtl/aud_tx_slot_match.sv
// Module: decides whether a slot request belongs to this FIFO. Assumes
// slot numbers and slot codes share one numbering; stereo claims the coded
// slot and the one after it, and code 12 cannot pair.
module aud_tx_slot_match
    import aud_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  tx_cfg_t    cfg,
    input  logic       req,
    input  logic [3:0] req_slot,
    output logic       hit
);

    logic       linked;
    logic       code_ok;
    logic [3:0] top_code;
    logic       lower_match;
    logic       upper_match;

    // Qualify configuration and compare the requested slot
    always_comb begin
        linked      = (cfg.link == LINK_ON);
        top_code    = cfg.stereo ? (SLOT_HIGH - 4'd1) : SLOT_HIGH;
        code_ok     = (cfg.slot >= SLOT_LOW) && (cfg.slot <= top_code);
        lower_match = (req_slot == cfg.slot);
        upper_match = cfg.stereo && (req_slot == cfg.slot + 4'd1);
        hit         = req && linked && code_ok && (lower_match || upper_match);
    end

    // R5: a stereo pair cannot start at the last slot
    p_no_pair_at_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.stereo && cfg.slot == SLOT_HIGH) |-> !hit);

    // R3: a link code other than 2'b10 never claims a slot
    p_unlinked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.link != LINK_ON) |-> !hit);

endmodule

// File: rtl/aud_tx_slot_fifo.sv
// Module: top of the transmit slot FIFO. Queues processor samples, answers
// matching slot requests one clock later with a left-aligned 20-bit value,
// flags underflow and drives a level interrupt on free space.
// Assumes at most one slot request per cycle from the frame builder.
module aud_tx_slot_fifo
    import aud_tx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SMP_W = 16,
    parameter int SLOT_W = 20,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PAD = SLOT_W - SMP_W,
    localparam int TW = (CW > 4) ? CW : 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              smp_wr,
    input  logic [SMP_W-1:0]  smp_wdata,
    input  logic              slot_req,
    input  logic [3:0]        slot_num,
    output logic              slot_valid,
    output logic [SLOT_W-1:0] slot_data,
    output logic              irq,
    output logic              dma_en
);

    tx_cfg_t          cfg;
    logic             uf_flag;
    logic             hit;
    logic             full;
    logic             empty;
    logic [CW-1:0]    level;
    logic [SMP_W-1:0] head;
    logic             starve;
    logic [TW-1:0]    free_cnt;
    logic [TW-1:0]    need_cnt;

    assign starve = hit && empty;
    assign dma_en = cfg.dma;

    aud_tx_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wdata   (cfg_wdata),
        .uf_set  (starve),
        .full    (full),
        .empty   (empty),
        .cfg     (cfg),
        .uf_flag (uf_flag),
        .rdata   (cfg_rdata)
    );

    aud_tx_slot_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg),
        .req      (slot_req),
        .req_slot (slot_num),
        .hit      (hit)
    );

    aud_tx_fifo_mem #(
        .DEPTH (DEPTH),
        .WIDTH (SMP_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (smp_wr),
        .push_data (smp_wdata),
        .pop       (hit),
        .head      (head),
        .full      (full),
        .empty     (empty),
        .level     (level)
    );

    // Compare free entries with the programmed threshold plus one
    always_comb begin
        free_cnt = TW'(CW'(DEPTH) - level);
        need_cnt = TW'(cfg.thresh) + TW'(1);
        irq      = (cfg.link == LINK_ON) && (free_cnt >= need_cnt);
    end

    // Register the slot answer: sample left-aligned, zero on starvation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 1'b0;
            slot_data  <= '0;
        end else begin
            slot_valid <= hit;
            if (hit && !empty) begin
                slot_data <= {head, {PAD{1'b0}}};
            end else begin
                slot_data <= '0;
            end
        end
    end

    // R7: the padding bits of every answered slot are zero
    p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_valid |-> (slot_data[PAD-1:0] == '0));

    // R8: a starved slot is answered with an all-zero value
    p_starve_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        starve |=> (slot_valid && slot_data == '0));

    // R9: no interrupt while the link is not enabled
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.link != LINK_ON) |-> !irq);

    // R7: a valid answer lasts one cycle unless another request hit
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !hit) |=> !slot_valid);

endmodule

// File: tb/aud_tx_slot_fifo_bench.sv
// Bench: scoreboard for the transmit slot FIFO. Driver tasks queue the
// expected slot values; a monitor compares every answered slot.
module aud_tx_slot_fifo_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        smp_wr = 1'b0;
    logic [15:0] smp_wdata = '0;
    logic        slot_req = 1'b0;
    logic [3:0]  slot_num = '0;
    logic        slot_valid;
    logic [19:0] slot_data;
    logic        irq;
    logic        dma_en;

    int checks = 0;
    int errors = 0;

    logic [15:0] model_q[$];
    logic [19:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    aud_tx_slot_fifo u_aud_tx_slot_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .smp_wr     (smp_wr),
        .smp_wdata  (smp_wdata),
        .slot_req   (slot_req),
        .slot_num   (slot_num),
        .slot_valid (slot_valid),
        .slot_data  (slot_data),
        .irq        (irq),
        .dma_en     (dma_en)
    );

    task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic push_sample(input logic [15:0] d);
        @(negedge clk);
        smp_wr    = 1'b1;
        smp_wdata = d;
        if (model_q.size() < 8) model_q.push_back(d);
        @(negedge clk);
        smp_wr    = 1'b0;
    endtask

    // Issue one slot request; when served, queue the expected answer
    task automatic request(input logic [3:0] s, input bit served, input string tag);
        @(negedge clk);
        slot_req = 1'b1;
        slot_num = s;
        if (served) begin
            if (model_q.size() > 0) exp_q.push_back({model_q.pop_front(), 4'h0});
            else exp_q.push_back(20'h0);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        slot_req = 1'b0;
    endtask

    // Monitor: compare each answered slot with the scoreboard head
    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        if (rst_n && slot_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3/R4/R5 unexpected slot answer: actual %h expected none", slot_data);
            end else begin
                chk(tag_q.pop_front(), slot_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", 20'(cfg_rdata), 20'h4000);
        chk("R1 reset irq", 20'(irq), 20'h0);
        chk("R1 reset valid", 20'(slot_valid), 20'h0);

        // Mono on slot 3, threshold 0
        write_cfg(16'h0032);
        chk("R9 irq empty fifo", 20'(irq), 20'h1);
        push_sample(16'hA001);
        push_sample(16'hA002);
        push_sample(16'hA003);
        request(4'd3, 1, "R7 mono slot 3 first");
        request(4'd4, 0, "R4 other slot");
        request(4'd3, 1, "R4 mono slot 3 second");
        request(4'd3, 1, "R2 order third");
        request(4'd3, 1, "R8 starved slot zero");
        @(negedge clk);
        chk("R8 underflow set", 20'(cfg_rdata[15]), 20'h1);
        write_cfg(16'h0032);
        chk("R8 write zero keeps flag", 20'(cfg_rdata[15]), 20'h1);
        write_cfg(16'h8032);
        chk("R8 write one clears", 20'(cfg_rdata[15]), 20'h0);

        // Link codes other than 2'b10 serve nothing
        push_sample(16'hB001);
        write_cfg(16'h0030);
        request(4'd3, 0, "R3 code 00");
        chk("R3 irq off when unlinked", 20'(irq), 20'h0);
        write_cfg(16'h0031);
        request(4'd3, 0, "R3 code 01");
        write_cfg(16'h0033);
        request(4'd3, 0, "R3 code 11");
        chk("R3 no underflow when unlinked", 20'(cfg_rdata[15]), 20'h0);
        write_cfg(16'h0032);
        request(4'd3, 1, "R3 sample kept while unlinked");

        // Fill beyond capacity, threshold 3 (irq when 4 free)
        write_cfg(16'h0332);
        for (int i = 0; i < 9; i++) push_sample(16'hC000 + 16'(i));
        chk("R2 full flag", 20'(cfg_rdata[13]), 20'h1);
        chk("R9 irq low when full", 20'(irq), 20'h0);
        for (int i = 0; i < 8; i++) begin
            request(4'd3, 1, "R2 drain order");
            chk("R9 irq vs free entries", 20'(irq), (i >= 3) ? 20'h1 : 20'h0);
        end
        chk("R2 empty flag", 20'(cfg_rdata[14]), 20'h1);
        request(4'd3, 1, "R2 extra sample dropped");
        write_cfg(16'h8332);

        // Stereo pair on slots 5 and 6
        write_cfg(16'h005A);
        push_sample(16'h1111);
        push_sample(16'h2222);
        push_sample(16'h3333);
        push_sample(16'h4444);
        request(4'd5, 1, "R6 left to lower slot");
        request(4'd6, 1, "R6 right to upper slot");
        request(4'd7, 0, "R5 slot past pair");
        request(4'd4, 0, "R5 slot before pair");
        request(4'd5, 1, "R5 second left");
        request(4'd6, 1, "R5 second right");

        // Stereo at code 12 is not allowed; mono at 12 works
        push_sample(16'h5555);
        write_cfg(16'h00CA);
        request(4'd12, 0, "R5 stereo code 12");
        request(4'd13, 0, "R5 stereo code 12 upper");
        write_cfg(16'h00C2);
        request(4'd12, 1, "R4 mono slot 12");

        // Reserved slot codes
        push_sample(16'h6666);
        write_cfg(16'h0022);
        request(4'd2, 0, "R4 reserved code 2");
        write_cfg(16'h00D2);
        request(4'd13, 0, "R4 reserved code 13");
        chk("R4 reserved left sample", 20'(cfg_rdata[14]), 20'h0);
        write_cfg(16'h0032);
        request(4'd3, 1, "R4 sample kept");

        // Ignored bits and DMA enable
        write_cfg(16'h7036);
        chk("R10 ignored bits", 20'(cfg_rdata), 20'h4032);
        write_cfg(16'h0832);
        chk("R11 dma readback", 20'(cfg_rdata), 20'h4832);
        chk("R11 dma output", 20'(dma_en), 20'h1);

        repeat (3) @(negedge clk);
        chk("R7 all expected answers seen", 20'(exp_q.size()), 20'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule